// File: doc/BRIEF.md
# Multi-Register Word Load Sequencer

This block performs a load of several consecutive 32-bit words into a run of general-purpose registers. The issuing pipeline supplies the index of the first target register, the index and current value of a base register, a signed displacement and the current byte-order mode. The block then reads one word per beat over a valid/ready memory port and writes each word into the next register, up to and including register 31. Every write clears the upper half of the 64-bit register.

Before any memory traffic, the request is checked. A base register that falls inside the span being loaded makes the form invalid. Little-endian mode is not supported and raises an alignment fault. In both cases the block ends without a single read or write and pulses an error output. Otherwise it pulses a completion output after the final register write. The register file and memory sit outside the block.

Top module: `word_burst_loader`

## Requirements
- R1: A valid operation writes exactly 32 minus the first index registers, in ascending order from the first index to 31, and issues the same number of memory reads.
- R2: The first read address is the base value plus the displacement sign-extended to 64 bits. When the base index is 0, the base value is ignored and treated as zero.
- R3: Each later read address is the previous one plus 4.
- R4: A register write happens in exactly the cycle a read response is accepted. Its data carries the returned word in bits 31:0 and zeros in bits 63:32.
- R5: If the base index is greater than or equal to the first index (this includes a first index of 0), the form is invalid. `form_err` pulses, and no read or register write is made.
- R6: If `le_mode` is high at start, `align_err` pulses, and no read or register write is made. This check wins over the form check.
- R7: At most one read is outstanding. `mem_req_valid` is never high while a response is awaited, and it holds with a stable address until `mem_req_ready`.
- R8: `start` is accepted only when the block is idle. A pulse during an operation changes neither its addresses, its registers nor its outcome.
- R9: Each operation ends with exactly one one-cycle pulse of `done`, `form_err` or `align_err`. `busy` falls in the following cycle. `done` comes in the cycle after the write to register 31.
- R10: After reset, `busy`, `done`, `form_err`, `align_err`, `mem_req_valid`, `mem_rsp_ready` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| first_idx | input | 5 | First target register index |
| base_idx | input | 5 | Base register index (0 means no base) |
| base_val | input | 64 | Current value of the base register |
| disp | input | 16 | Signed byte displacement |
| le_mode | input | 1 | Little-endian mode active |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block accepts read data |
| mem_rsp_data | input | 32 | Returned word |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Successful completion pulse |
| form_err | output | 1 | Invalid-form pulse |
| align_err | output | 1 | Byte-order fault pulse |

## Verification
The load is tried with short runs (one and four words), a 31-word run from register 1, and a run with a zero base index whose base value must be ignored. Stored words have bit 31 set, so a sign extension of the data would be caught. The reject cases sit on both sides of the form boundary: base equal to first, base one below first, base 31 and first index 0. The little-endian case is also combined with an invalid form, to show which error takes precedence. Memory stalls on both the request and the response side show that the address holds and that only one read is outstanding. A start pulse in the middle of a run, carrying different operands, must leave that run unchanged.

// File: rtl/wbl_pkg.sv
// Shared types for the multi-register word load sequencer.
package wbl_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_REQ   = 3'd2,
        S_WAIT  = 3'd3,
        S_DONE  = 3'd4
    } wbl_state_t;
endpackage

// File: rtl/wbl_precheck.sv
// Combinational screening of a latched request: computes the starting
// effective address and flags the two reject conditions.
// Assumes the operands are held stable while the controller is in CHECK.
module wbl_precheck #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              le_mode,
    output logic [XLEN-1:0]   start_addr,
    output logic              form_bad,
    output logic              order_bad
);
    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] disp_ext;

    // Base of zero when index 0; displacement sign-extended; sum.
    always_comb begin
        base_eff   = (base_idx == '0) ? '0 : base_val;
        disp_ext   = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
        start_addr = base_eff + disp_ext;
    end

    // Base inside [first_idx, last register] is an invalid form.
    assign form_bad  = (base_idx >= first_idx);
    assign order_bad = le_mode;
endmodule

// File: rtl/wbl_cursor.sv
// Address and register-index cursor. Loads the start point on 'load',
// advances by one word and one register on 'advance'.
// Assumes load and advance are never asserted together.
module wbl_cursor #(
    parameter int XLEN   = 64,
    parameter int IDX_W  = 5,
    parameter int STEP   = 4,
    parameter int LAST   = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [XLEN-1:0]  load_addr,
    input  logic [IDX_W-1:0] load_idx,
    output logic [XLEN-1:0]  addr,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    // Cursor registers: restart on load, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            idx  <= '0;
        end else if (load) begin
            addr <= load_addr;
            idx  <= load_idx;
        end else if (advance) begin
            addr <= addr + XLEN'(STEP);
            idx  <= idx + IDX_W'(1);
        end
    end

    assign at_last = (idx == IDX_W'(LAST));
endmodule

// File: rtl/word_burst_loader.sv
// Multi-register word load sequencer. Latches the operands on start, screens
// them (byte order, base-in-range), then performs one word read per target
// register from first_idx to NREG-1. Each word is written zero-extended.
// Assumes the memory keeps one response per accepted request, in order.
module word_burst_loader #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int NREG   = 32,
    parameter int DISP_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              le_mode,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              busy,
    output logic              done,
    output logic              form_err,
    output logic              align_err
);
    import wbl_pkg::*;

    localparam int STEP = WORD_W / 8;
    localparam int LAST = NREG - 1;

    wbl_state_t        state;
    logic [IDX_W-1:0]  first_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [XLEN-1:0]   bval_q;
    logic [DISP_W-1:0] disp_q;
    logic              le_q;
    logic              fail_form_q;
    logic              fail_order_q;

    logic [XLEN-1:0]   start_addr;
    logic              form_bad;
    logic              order_bad;
    logic [XLEN-1:0]   cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic              at_last;
    logic              beat_take;

    wbl_precheck #(
        .XLEN   (XLEN),
        .DISP_W (DISP_W),
        .IDX_W  (IDX_W)
    ) u_precheck (
        .first_idx  (first_q),
        .base_idx   (bidx_q),
        .base_val   (bval_q),
        .disp       (disp_q),
        .le_mode    (le_q),
        .start_addr (start_addr),
        .form_bad   (form_bad),
        .order_bad  (order_bad)
    );

    assign beat_take = (state == S_WAIT) && mem_rsp_valid;

    wbl_cursor #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W),
        .STEP  (STEP),
        .LAST  (LAST)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == S_CHECK),
        .advance   (beat_take),
        .load_addr (start_addr),
        .load_idx  (first_q),
        .addr      (cur_addr),
        .idx       (cur_idx),
        .at_last   (at_last)
    );

    // Operand capture: only an idle block samples a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            bidx_q  <= '0;
            bval_q  <= '0;
            disp_q  <= '0;
            le_q    <= 1'b0;
        end else if (state == S_IDLE && start) begin
            first_q <= first_idx;
            bidx_q  <= base_idx;
            bval_q  <= base_val;
            disp_q  <= disp;
            le_q    <= le_mode;
        end
    end

    // Control sequence: screen, then request/await one word per register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            fail_form_q  <= 1'b0;
            fail_order_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state        <= S_CHECK;
                        fail_form_q  <= 1'b0;
                        fail_order_q <= 1'b0;
                    end
                end
                S_CHECK: begin
                    if (order_bad) begin
                        fail_order_q <= 1'b1;
                        state        <= S_DONE;
                    end else if (form_bad) begin
                        fail_form_q <= 1'b1;
                        state       <= S_DONE;
                    end else begin
                        state <= S_REQ;
                    end
                end
                S_REQ: begin
                    if (mem_req_ready) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (mem_rsp_valid) state <= at_last ? S_DONE : S_REQ;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Port drive from state and cursor.
    always_comb begin
        mem_req_valid = (state == S_REQ);
        mem_req_addr  = cur_addr;
        mem_rsp_ready = (state == S_WAIT);
        rf_we         = beat_take;
        rf_waddr      = cur_idx;
        rf_wdata      = {{(XLEN-WORD_W){1'b0}}, mem_rsp_data};
        busy          = (state != S_IDLE);
        done          = (state == S_DONE) && !fail_form_q && !fail_order_q;
        form_err      = (state == S_DONE) && fail_form_q;
        align_err     = (state == S_DONE) && fail_order_q;
    end
endmodule

// File: rtl/wbl_checker.sv
// Protocol and sequencing properties for word_burst_loader, bound to it.
// Assumes it observes the top-level ports only, plus its own tracking state.
module wbl_checker #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int NREG   = 32,
    parameter int DISP_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [XLEN-1:0]   mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_ready,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_waddr,
    input logic [XLEN-1:0]   rf_wdata,
    input logic              busy,
    input logic              done,
    input logic              form_err,
    input logic              align_err
);
    logic [XLEN-1:0]  prev_addr;
    logic             have_prev;
    logic [IDX_W-1:0] prev_w;
    logic             have_w;
    logic             traffic;
    logic             finish;

    assign finish = done || form_err || align_err;

    // Per-operation history; cleared whenever the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            prev_addr <= '0;
            have_prev <= 1'b0;
            prev_w    <= '0;
            have_w    <= 1'b0;
            traffic   <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                prev_addr <= mem_req_addr;
                have_prev <= 1'b1;
                traffic   <= 1'b1;
            end
            if (rf_we) begin
                prev_w  <= rf_waddr;
                have_w  <= 1'b1;
                traffic <= 1'b1;
            end
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R7
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && mem_rsp_ready));
    // R4
    wr_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we == (mem_rsp_valid && mem_rsp_ready));
    // R4
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wdata[XLEN-1:WORD_W] == '0);
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && have_prev
        |-> mem_req_addr == prev_addr + XLEN'(WORD_W / 8));
    // R1
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && have_w |-> rf_waddr == prev_w + IDX_W'(1));
    // R9
    last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_waddr == IDX_W'(NREG - 1) |=> done);
    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, form_err, align_err}));
    // R9
    outcome_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish && !busy);
    // R5
    form_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        form_err |-> !traffic);
    // R6
    order_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !traffic);
endmodule

bind word_burst_loader wbl_checker #(
    .XLEN   (XLEN),
    .WORD_W (WORD_W),
    .NREG   (NREG),
    .DISP_W (DISP_W)
) i_wbl_checker (.*);

// File: tb/test_word_burst_loader.sv
// Directed bench for word_burst_loader with a bench-side memory model.
module test_word_burst_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  first_idx = '0;
    logic [4:0]  base_idx = '0;
    logic [63:0] base_val = '0;
    logic [15:0] disp = '0;
    logic        le_mode = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [63:0] rf_wdata;
    logic        busy, done, form_err, align_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int req_stall = 0;
    int rsp_lat   = 0;

    logic [63:0] req_log [64];
    logic [4:0]  wr_idx  [64];
    logic [63:0] wr_dat  [64];
    int req_n = 0;
    int wr_n  = 0;

    word_burst_loader i_word_burst_loader (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return ~a[31:0];
    endfunction

    // Memory model: acts on falling edges, one request at a time.
    logic        pend = 1'b0;
    int          cnt = 0;
    int          stall_cnt = 0;
    logic [63:0] held_addr = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            pend = 1'b0;
            stall_cnt = req_stall;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            pend = 1'b0;
            stall_cnt = req_stall;
        end else if (mem_req_ready) begin
            mem_req_ready = 1'b0;
            pend = 1'b1;
            cnt = rsp_lat;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem_word(held_addr);
            end else cnt--;
        end else if (mem_req_valid) begin
            if (stall_cnt == 0) begin
                mem_req_ready = 1'b1;
                held_addr = mem_req_addr;
            end else stall_cnt--;
        end
    end

    // Traffic log taken at rising edges.
    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            if (mem_req_valid && mem_req_ready && req_n < 64) begin
                req_log[req_n] = mem_req_addr;
                req_n++;
            end
            if (rf_we && wr_n < 64) begin
                wr_idx[wr_n] = rf_waddr;
                wr_dat[wr_n] = rf_wdata;
                wr_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Launch one operation, optionally poke start mid-run, then verify.
    task automatic run_op(input string tag, input logic [4:0] f, input logic [4:0] b,
                          input logic [63:0] bv, input logic [15:0] d, input logic le,
                          input int rs, input int rl, input bit poke);
        logic [63:0] ea;
        int expn;
        bit got_done, got_form, got_align, seen;
        @(negedge clk);
        req_stall = rs; rsp_lat = rl; stall_cnt = rs;
        req_n = 0; wr_n = 0;
        first_idx = f; base_idx = b; base_val = bv; disp = d; le_mode = le;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (poke && i == 4) begin
                first_idx = 5'd0; base_idx = 5'd7; base_val = 64'hFFFF;
                disp = 16'h0100; le_mode = 1'b1; start = 1'b1;
            end else start = 1'b0;
            if (done || form_err || align_err) begin
                seen = 1;
                got_done = done; got_form = form_err; got_align = align_err;
            end else @(negedge clk);
        end
        start = 1'b0;
        chk(seen, "R9", {tag, " finished"}, 64'(seen), 64'd1);
        if (!seen) return;
        ea = ((b == 0) ? 64'd0 : bv) + {{48{d[15]}}, d};
        expn = 32 - int'(f);
        if (le) begin
            chk(got_align && !got_form && !got_done, "R6", {tag, " align error only"},
                {61'd0, got_done, got_form, got_align}, 64'd1);
        end else if (b >= f) begin
            chk(got_form && !got_align && !got_done, "R5", {tag, " form error only"},
                {61'd0, got_done, got_form, got_align}, 64'd2);
        end else begin
            chk(got_done && !got_form && !got_align, "R9", {tag, " done only"},
                {61'd0, got_done, got_form, got_align}, 64'd4);
        end
        @(negedge clk);
        chk(!done && !form_err && !align_err && !busy, "R9", {tag, " one-cycle outcome"},
            {60'd0, busy, done, form_err, align_err}, 64'd0);
        if (le || b >= f) begin
            chk(req_n == 0 && wr_n == 0, le ? "R6" : "R5", {tag, " no traffic"},
                64'(req_n + wr_n), 64'd0);
        end else begin
            chk(wr_n == expn && req_n == expn, poke ? "R8" : "R1", {tag, " beat count"},
                64'(wr_n), 64'(expn));
            for (int k = 0; k < expn && k < 64; k++) begin
                chk(req_log[k] == ea + 64'(4 * k), (k == 0) ? "R2" : "R3",
                    {tag, " read address"}, req_log[k], ea + 64'(4 * k));
                chk(wr_idx[k] == f + 5'(k), "R1", {tag, " register index"},
                    64'(wr_idx[k]), 64'(f + 5'(k)));
                chk(wr_dat[k] == {32'd0, mem_word(ea + 64'(4 * k))}, "R4",
                    {tag, " zero-extended data"}, wr_dat[k],
                    {32'd0, mem_word(ea + 64'(4 * k))});
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !done && !form_err && !align_err && !mem_req_valid
            && !mem_rsp_ready && !rf_we, "R10", "reset outputs low",
            {57'd0, busy, done, form_err, align_err, mem_req_valid, mem_rsp_ready, rf_we},
            64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        run_op("four words",    5'd28, 5'd3,  64'h1000,          16'hFFF8, 1'b0, 0, 0, 0);
        run_op("single word",   5'd31, 5'd5,  64'h0000_0040_0000, 16'h0010, 1'b0, 1, 2, 0);
        run_op("zero base",     5'd30, 5'd0,  64'hDEAD_0000_0000, 16'h0200, 1'b0, 0, 1, 0);
        run_op("long run",      5'd1,  5'd0,  64'h5555,          16'h7FFC, 1'b0, 2, 3, 0);
        run_op("base below",    5'd10, 5'd9,  64'h3000,          16'h8000, 1'b0, 0, 0, 0);
        run_op("base equal",    5'd10, 5'd10, 64'h3000,          16'h0000, 1'b0, 0, 0, 0);
        run_op("base top",      5'd20, 5'd31, 64'h3000,          16'h0000, 1'b0, 0, 0, 0);
        run_op("first zero",    5'd0,  5'd0,  64'h3000,          16'h0000, 1'b0, 0, 0, 0);
        run_op("little endian", 5'd25, 5'd2,  64'h3000,          16'h0000, 1'b1, 0, 0, 0);
        run_op("le over form",  5'd25, 5'd26, 64'h3000,          16'h0000, 1'b1, 0, 0, 0);
        run_op("busy start",    5'd29, 5'd2,  64'h2000,          16'h0000, 1'b0, 3, 4, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule